// File: doc/BRIEF.md
# Sensor-Driven Two-Road Signal Controller

This block sequences the lights at a crossing of a north/south road and an east/west road. It is a Moore machine with four phases: north/south go, north/south warning, east/west go and east/west warning. A go phase is held for as long as no car waits on the crossing road. When the car-present bit of the crossing road is high, the machine moves to the warning phase. Every warning phase lasts exactly one cycle and then hands the right of way to the other road. No timer is involved: only the sensors and the clock decide the sequence.

Both lamp outputs come straight from the phase register, so they change one clock edge after the sensor input that caused the change. The safety rules are checked by assertions inside the RTL. No green may show on both roads at once, and no lamp may go from green to red without a yellow cycle in between. The sensor bits are plain level inputs with no handshake. No data moves through this block, so it has no valid/ready interface.

Top module: `xroad_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in north/south go. One edge after a reset edge, `ns_lamp` is green and `ew_lamp` is red. Lamp codes are 2'b00 red, 2'b01 yellow and 2'b10 green.
- R2: In north/south go with `ew_car` low, the machine stays in north/south go, whatever the value of `ns_car`.
- R3: In north/south go with `ew_car` high, the next edge sets `ns_lamp` to yellow and `ew_lamp` to red.
- R4: North/south yellow lasts exactly one cycle. The next edge always gives `ns_lamp` red and `ew_lamp` green, whatever the sensor values.
- R5: In east/west go with `ns_car` low, the machine stays in east/west go, whatever the value of `ew_car`.
- R6: In east/west go with `ns_car` high, the next edge sets `ew_lamp` to yellow and `ns_lamp` to red.
- R7: East/west yellow lasts exactly one cycle. The next edge always gives `ns_lamp` green and `ew_lamp` red, whatever the sensor values.
- R8: The two lamps are never green in the same cycle.
- R9: A lamp that is green is never red on the following cycle.
- R10: The code 2'b11 is never driven on either lamp.
- R11: If a car is held on the road that is waiting at red while the other road has green, the waiting road shows green two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ns_car | input | 1 | Car waiting on the north/south road |
| ew_car | input | 1 | Car waiting on the east/west road |
| ns_lamp | output | 2 | North/south lamp: 00 red, 01 yellow, 10 green |
| ew_lamp | output | 2 | East/west lamp: 00 red, 01 yellow, 10 green |

## Verification
The hardest cases to reach from the ports are the ones where a sensor should have no effect. One is a car on the road that already has green. The other is any sensor value during the single yellow cycle. A wrong design shows the fault only in the cycle after that input. The vector table therefore places both sensors high in go phases and in yellow phases. It also places a reset while the machine sits in a yellow phase. A random sensor stream is then compared edge by edge against a separate phase model in the bench. Finally, sensors are held on the waiting road to confirm that green arrives two edges later in each direction.

// File: rtl/xroad_pkg.sv
package xroad_pkg;
  localparam int LAMP_W  = 2;
  localparam int N_ROADS = 2;

  typedef enum logic [1:0] {
    PH_NS_GO   = 2'd0,
    PH_NS_WARN = 2'd1,
    PH_EW_GO   = 2'd2,
    PH_EW_WARN = 2'd3
  } phase_e;

  localparam logic [LAMP_W-1:0] LAMP_RED   = 2'b00;
  localparam logic [LAMP_W-1:0] LAMP_AMBER = 2'b01;
  localparam logic [LAMP_W-1:0] LAMP_GREEN = 2'b10;

  // Road index 0 is north/south, index 1 is east/west.
  function automatic phase_e go_phase(input int road);
    return (road == 0) ? PH_NS_GO : PH_EW_GO;
  endfunction

  function automatic phase_e warn_phase(input int road);
    return (road == 0) ? PH_NS_WARN : PH_EW_WARN;
  endfunction
endpackage

// File: rtl/xroad_step.sv
module xroad_step
  import xroad_pkg::*;
(
  input  phase_e cur_i,
  input  logic   ns_car_i,
  input  logic   ew_car_i,
  output phase_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    case (cur_i)
      PH_NS_GO:   if (ew_car_i) nxt_o = PH_NS_WARN;
      PH_NS_WARN: nxt_o = PH_EW_GO;
      PH_EW_GO:   if (ns_car_i) nxt_o = PH_EW_WARN;
      PH_EW_WARN: nxt_o = PH_NS_GO;
      default:    nxt_o = PH_NS_GO;
    endcase
  end
endmodule

// File: rtl/xroad_lamps.sv
module xroad_lamps
  import xroad_pkg::*;
(
  input  phase_e                           phase_i,
  output logic [N_ROADS-1:0][LAMP_W-1:0]   lamp_o
);
  for (genvar r = 0; r < N_ROADS; r++) begin : g_road
    localparam phase_e GO_PH   = go_phase(r);
    localparam phase_e WARN_PH = warn_phase(r);
    assign lamp_o[r] = (phase_i == GO_PH)   ? LAMP_GREEN :
                       (phase_i == WARN_PH) ? LAMP_AMBER : LAMP_RED;
  end
endmodule

// File: rtl/xroad_ctrl.sv
module xroad_ctrl
  import xroad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ns_car,
  input  logic       ew_car,
  output logic [1:0] ns_lamp,
  output logic [1:0] ew_lamp
);
  phase_e phase_q;
  phase_e phase_d;
  logic [N_ROADS-1:0][LAMP_W-1:0] lamps;

  xroad_step u_step (
    .cur_i    (phase_q),
    .ns_car_i (ns_car),
    .ew_car_i (ew_car),
    .nxt_o    (phase_d)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_NS_GO;
    else     phase_q <= phase_d;
  end

  xroad_lamps u_lamps (
    .phase_i (phase_q),
    .lamp_o  (lamps)
  );

  assign ns_lamp = lamps[0];
  assign ew_lamp = lamps[1];

  // R1
  reset_go_chk: assert property (@(posedge clk)
    rst |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));

  // R2
  ns_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp == LAMP_GREEN && !ew_car) |=> (ns_lamp == LAMP_GREEN));

  // R3
  ns_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp == LAMP_GREEN && ew_car) |=> (ns_lamp == LAMP_AMBER && ew_lamp == LAMP_RED));

  // R4
  ns_amber_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp == LAMP_AMBER) |=> (ns_lamp == LAMP_RED && ew_lamp == LAMP_GREEN));

  // R5
  ew_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LAMP_GREEN && !ns_car) |=> (ew_lamp == LAMP_GREEN));

  // R6
  ew_warn_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LAMP_GREEN && ns_car) |=> (ew_lamp == LAMP_AMBER && ns_lamp == LAMP_RED));

  // R7
  ew_amber_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LAMP_AMBER) |=> (ns_lamp == LAMP_GREEN && ew_lamp == LAMP_RED));

  // R8
  no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
    !(ns_lamp == LAMP_GREEN && ew_lamp == LAMP_GREEN));

  // R9
  ns_no_skip_amber_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp == LAMP_GREEN) |=> (ns_lamp != LAMP_RED));

  // R9
  ew_no_skip_amber_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LAMP_GREEN) |=> (ew_lamp != LAMP_RED));

  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp != 2'b11 && ew_lamp != 2'b11));
endmodule

// File: tb/xroad_ctrl_bench.sv
`timescale 1ns/1ps
module xroad_ctrl_bench;
  localparam logic [1:0] RD = 2'b00;
  localparam logic [1:0] YL = 2'b01;
  localparam logic [1:0] GN = 2'b10;

  // Fields: req[3:0], rst, ns_car, ew_car, exp_ns[1:0], exp_ew[1:0]
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 1'b0, GN, RD},  // R1 reset
    {4'd2, 1'b0, 1'b1, 1'b0, GN, RD},  // R2 own-road car ignored
    {4'd3, 1'b0, 1'b0, 1'b1, YL, RD},  // R3
    {4'd4, 1'b0, 1'b0, 1'b0, RD, GN},  // R4
    {4'd5, 1'b0, 1'b0, 1'b1, RD, GN},  // R5 own-road car ignored
    {4'd5, 1'b0, 1'b0, 1'b0, RD, GN},  // R5
    {4'd6, 1'b0, 1'b1, 1'b0, RD, YL},  // R6
    {4'd7, 1'b0, 1'b0, 1'b1, GN, RD},  // R7 inputs ignored
    {4'd3, 1'b0, 1'b1, 1'b1, YL, RD},  // R3 both cars
    {4'd4, 1'b0, 1'b1, 1'b1, RD, GN},  // R4 inputs ignored
    {4'd6, 1'b0, 1'b1, 1'b1, RD, YL},  // R6 both cars
    {4'd7, 1'b0, 1'b0, 1'b0, GN, RD},  // R7
    {4'd3, 1'b0, 1'b0, 1'b1, YL, RD},  // R3
    {4'd1, 1'b1, 1'b1, 1'b0, GN, RD}   // R1 reset from yellow
  };

  logic clk = 1'b0;
  logic rst, ns_car, ew_car;
  logic [1:0] ns_lamp, ew_lamp;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  xroad_ctrl u_xroad_ctrl (
    .clk(clk), .rst(rst), .ns_car(ns_car), .ew_car(ew_car),
    .ns_lamp(ns_lamp), .ew_lamp(ew_lamp)
  );

  task automatic check(input string req, input logic [1:0] e_ns, input logic [1:0] e_ew);
    checks++;
    if (ns_lamp !== e_ns || ew_lamp !== e_ew) begin
      fails++;
      $display("FAIL %s: ns/ew actual %b/%b expected %b/%b", req, ns_lamp, ew_lamp, e_ns, e_ew);
    end
  endtask

  // Inputs are set after a falling edge, then one rising edge, then a sample at the next falling edge.
  task automatic step(input logic r, input logic n, input logic e);
    rst = r; ns_car = n; ew_car = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Bench phase model: 0 ns go, 1 ns yellow, 2 ew go, 3 ew yellow
  function automatic int ref_next(input int ph, input logic n, input logic e);
    case (ph)
      0: return e ? 1 : 0;
      1: return 2;
      2: return n ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] ref_lamps(input int ph);
    case (ph)
      0: return {GN, RD};
      1: return {YL, RD};
      2: return {RD, GN};
      default: return {RD, YL};
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ph;
    logic [3:0] exp_l;
    rst = 1'b1; ns_car = 1'b0; ew_car = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("R%0d table step %0d", VEC[i][10:7], i), VEC[i][3:2], VEC[i][1:0]);
    end

    // Random sensor stream against the bench model (R2 to R10).
    step(1'b1, 1'b0, 1'b0);
    ph = 0;
    for (int i = 0; i < 400; i++) begin
      logic n, e;
      logic [1:0] prev_ns, prev_ew;
      n = 1'($urandom_range(0, 1));
      e = 1'($urandom_range(0, 1));
      prev_ns = ns_lamp; prev_ew = ew_lamp;
      step(1'b0, n, e);
      ph = ref_next(ph, n, e);
      exp_l = ref_lamps(ph);
      check("R2 R3 R4 R5 R6 R7 random model", exp_l[3:2], exp_l[1:0]);
      checks++;
      if (ns_lamp == GN && ew_lamp == GN) begin
        fails++; $display("FAIL R8: actual both green expected at most one");
      end
      checks++;
      if ((prev_ns == GN && ns_lamp == RD) || (prev_ew == GN && ew_lamp == RD)) begin
        fails++; $display("FAIL R9: actual green to red expected yellow between");
      end
      checks++;
      if (ns_lamp == 2'b11 || ew_lamp == 2'b11) begin
        fails++; $display("FAIL R10: actual %b/%b expected no 11 code", ns_lamp, ew_lamp);
      end
    end

    // R11: waiting east/west car held from north/south go.
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check("R11 east/west green two edges after car", RD, GN);
    // R11: waiting north/south car held from east/west go.
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R11 north/south green two edges after car", GN, RD);

    // R2 long idle with own-road car only.
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);
    check("R2 long hold with own-road car", GN, RD);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule